// File: doc/BRIEF.md
# Timer-Assisted Four-State Sequence Controller

This block is a synchronous Moore machine that steps through four states in a fixed ring: an arm state, a dwell state, a qualify state and a release state. It leaves the arm state on an input match, leaves the dwell state after a fixed number of cycles, and leaves the qualify state only after a minimum number of cycles and on a second input match. From the release state it goes back to arm. One auxiliary counter serves every timed state. It is cleared whenever the state changes and is held at zero wherever no timing is needed. Every timed exit uses a greater-or-equal test with a fall-through branch that keeps the state, so the machine cannot stall on a counter that runs past its limit.

The block is used where a short handshake has this shape: wait for a start code, hold for a settle period, then wait for a completion code that only counts after a minimum hold. The state code and a per-state output word are both available on ports. Both match codes, both durations and the four output words are compile-time parameters.

Top module: `tmr_fsm_top`

## Requirements
- R1: In the arm state (code 0), the machine moves to the dwell state (code 1) on the first rising edge at which `x_i` equals `X1`. At every other edge it stays in arm.
- R2: The dwell state (code 1) lasts exactly `T1` clock cycles, whatever the value of `x_i`. The machine then enters the qualify state (code 2).
- R3: From the qualify state (code 2), the machine moves to the release state (code 3) at the first rising edge at which `x_i` equals `X2` and at least `T2` cycles have been spent in qualify. A match that comes earlier has no effect, and the machine stays in qualify.
- R4: From the release state (code 3), the machine returns to arm on the next rising edge, whatever the value of `x_i`.
- R5: The internal counter restarts from zero at every state change. The dwell length and the minimum qualify hold are therefore measured from the entry into each state, however many times the ring has been traversed.
- R6: The counter is held at zero in the arm and release states. In a timed state it never counts past the larger of `T1` and `T2` less one. A dwell that follows a long wait in arm still lasts `T1` cycles. A match on `X2` after a long stay in qualify is still taken on the same edge.
- R7: `y_o` is registered and, in the same cycle, equals the parameter word of the current state: `Y_ARM`, `Y_DWELL`, `Y_QUAL` or `Y_REL` for state codes 0, 1, 2 and 3.
- R8: A synchronous active-high `rst` puts the machine in the arm state, sets `y_o` to `Y_ARM` and clears the counter, also when `rst` is asserted mid-sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x_i | input | XW | Input code compared with X1 and X2 |
| y_o | output | YW | Registered output word of the current state |
| state_o | output | 2 | Current state code (0 arm, 1 dwell, 2 qualify, 3 release) |

## Verification
In the qualify state, the elapsed-time condition and the `X2` match can become true in the same cycle. They can also become true in different cycles. The bench presents `X2` on the first qualify cycle and then removes it, holds it steady from entry so that both conditions first hold together on the `T2`-th edge, and withholds it long past `T2` before presenting it. A per-cycle model of the state and the output word judges each case. The model tracks the dwell time in each state from the requirements and does not read the design's counter.

// File: rtl/tmr_fsm_pkg.sv
package tmr_fsm_pkg;

    typedef enum logic [1:0] {
        ST_ARM   = 2'd0,
        ST_DWELL = 2'd1,
        ST_QUAL  = 2'd2,
        ST_REL   = 2'd3
    } ctl_state_t;

    typedef struct packed {
        ctl_state_t nxt;
        logic       moves;
    } step_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_timed(input ctl_state_t s);
        return (s == ST_DWELL) || (s == ST_QUAL);
    endfunction

endpackage

// File: rtl/tmr_fsm_timer.sv
module tmr_fsm_timer
    import tmr_fsm_pkg::*;
#(
    parameter int unsigned TW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic [TW-1:0] limit_m1,
    output logic [TW-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            count <= '0;
        end else if (count < limit_m1) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_fsm_next.sv
module tmr_fsm_next
    import tmr_fsm_pkg::*;
#(
    parameter int unsigned          XW     = 4,
    parameter int unsigned          TW     = 2,
    parameter logic [XW-1:0]        X1     = 4'h5,
    parameter logic [XW-1:0]        X2     = 4'hA,
    parameter logic [TW-1:0]        LIM_DW = '0,
    parameter logic [TW-1:0]        LIM_QU = '0
) (
    input  ctl_state_t    cur,
    input  logic [XW-1:0] x,
    input  logic [TW-1:0] count,
    output step_t         step
);

    always_comb begin
        step.nxt = cur;
        unique case (cur)
            ST_ARM: begin
                if (x == X1) step.nxt = ST_DWELL;
                else         step.nxt = ST_ARM;
            end
            ST_DWELL: begin
                if (count >= LIM_DW) step.nxt = ST_QUAL;
                else                 step.nxt = ST_DWELL;
            end
            ST_QUAL: begin
                if ((count >= LIM_QU) && (x == X2)) step.nxt = ST_REL;
                else                                step.nxt = ST_QUAL;
            end
            ST_REL: step.nxt = ST_ARM;
            default: step.nxt = ST_ARM;
        endcase
        step.moves = (step.nxt != cur);
    end

endmodule

// File: rtl/tmr_fsm_yreg.sv
module tmr_fsm_yreg
    import tmr_fsm_pkg::*;
#(
    parameter int unsigned   YW      = 8,
    parameter logic [YW-1:0] Y_ARM   = 8'h11,
    parameter logic [YW-1:0] Y_DWELL = 8'h22,
    parameter logic [YW-1:0] Y_QUAL  = 8'h44,
    parameter logic [YW-1:0] Y_REL   = 8'h88
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_state_t    nxt,
    output logic [YW-1:0] y
);

    logic [YW-1:0] y_d;

    always_comb begin
        unique case (nxt)
            ST_ARM:   y_d = Y_ARM;
            ST_DWELL: y_d = Y_DWELL;
            ST_QUAL:  y_d = Y_QUAL;
            ST_REL:   y_d = Y_REL;
            default:  y_d = Y_ARM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) y <= Y_ARM;
        else     y <= y_d;
    end

endmodule

// File: rtl/tmr_fsm_top.sv
module tmr_fsm_top
    import tmr_fsm_pkg::*;
#(
    parameter int unsigned   XW      = 4,
    parameter int unsigned   YW      = 8,
    parameter int unsigned   T1      = 4,
    parameter int unsigned   T2      = 3,
    parameter logic [XW-1:0] X1      = 4'h5,
    parameter logic [XW-1:0] X2      = 4'hA,
    parameter logic [YW-1:0] Y_ARM   = 8'h11,
    parameter logic [YW-1:0] Y_DWELL = 8'h22,
    parameter logic [YW-1:0] Y_QUAL  = 8'h44,
    parameter logic [YW-1:0] Y_REL   = 8'h88
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [XW-1:0] x_i,
    output logic [YW-1:0] y_o,
    output logic [1:0]    state_o
);

    localparam int unsigned   TMAX   = max_u(T1, T2);
    localparam int unsigned   TW     = cnt_width(TMAX);
    localparam logic [TW-1:0] LIM_DW = TW'(T1 - 1);
    localparam logic [TW-1:0] LIM_QU = TW'(T2 - 1);
    localparam logic [TW-1:0] LIM_MX = TW'(TMAX - 1);

    ctl_state_t    cur_q;
    step_t         step;
    logic [TW-1:0] count;
    logic [TW-1:0] limit_m1;
    logic          run;

    assign run      = is_timed(cur_q);
    assign limit_m1 = (cur_q == ST_DWELL) ? LIM_DW : LIM_QU;

    tmr_fsm_next #(
        .XW(XW), .TW(TW), .X1(X1), .X2(X2), .LIM_DW(LIM_DW), .LIM_QU(LIM_QU)
    ) u_next (
        .cur(cur_q), .x(x_i), .count(count), .step(step)
    );

    tmr_fsm_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .clear(step.moves), .run(run),
        .limit_m1(limit_m1), .count(count)
    );

    tmr_fsm_yreg #(
        .YW(YW), .Y_ARM(Y_ARM), .Y_DWELL(Y_DWELL), .Y_QUAL(Y_QUAL), .Y_REL(Y_REL)
    ) u_yreg (
        .clk(clk), .rst(rst), .nxt(step.nxt), .y(y_o)
    );

    always_ff @(posedge clk) begin
        if (rst) cur_q <= ST_ARM;
        else     cur_q <= step.nxt;
    end

    assign state_o = cur_q;

    // R1
    a_r1_arm_exit: assert property (@(posedge clk) disable iff (rst)
        (cur_q == ST_ARM && x_i == X1) |=> (cur_q == ST_DWELL));
    a_r1_arm_hold: assert property (@(posedge clk) disable iff (rst)
        (cur_q == ST_ARM && x_i != X1) |=> (cur_q == ST_ARM));
    // R2
    a_r2_dwell_hold: assert property (@(posedge clk) disable iff (rst)
        (cur_q == ST_DWELL && count < LIM_DW) |=> (cur_q == ST_DWELL));
    a_r2_dwell_exit: assert property (@(posedge clk) disable iff (rst)
        (cur_q == ST_DWELL && count >= LIM_DW) |=> (cur_q == ST_QUAL));
    // R3
    a_r3_qual_hold: assert property (@(posedge clk) disable iff (rst)
        (cur_q == ST_QUAL && (count < LIM_QU || x_i != X2)) |=> (cur_q == ST_QUAL));
    a_r3_qual_exit: assert property (@(posedge clk) disable iff (rst)
        (cur_q == ST_QUAL && count >= LIM_QU && x_i == X2) |=> (cur_q == ST_REL));
    // R4
    a_r4_rel_return: assert property (@(posedge clk) disable iff (rst)
        (cur_q == ST_REL) |=> (cur_q == ST_ARM));
    // R5
    a_r5_fresh_count: assert property (@(posedge clk) disable iff (rst)
        (cur_q != $past(cur_q)) |-> (count == '0));
    // R6
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (cur_q == ST_ARM || cur_q == ST_REL) |-> (count == '0));
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= LIM_MX);
    // R7
    a_r7_y_tracks_state: assert property (@(posedge clk) disable iff (rst)
        y_o == ((cur_q == ST_ARM)   ? Y_ARM :
                (cur_q == ST_DWELL) ? Y_DWELL :
                (cur_q == ST_QUAL)  ? Y_QUAL : Y_REL));
    // R8
    a_r8_reset_arm: assert property (@(posedge clk)
        rst |=> (cur_q == ST_ARM && count == '0 && y_o == Y_ARM));

endmodule

// File: tb/tmr_fsm_top_bench.sv
module tmr_fsm_top_bench;

    localparam int unsigned   XW      = 4;
    localparam int unsigned   YW      = 8;
    localparam int unsigned   T1      = 4;
    localparam int unsigned   T2      = 3;
    localparam logic [XW-1:0] X1      = 4'h5;
    localparam logic [XW-1:0] X2      = 4'hA;
    localparam logic [YW-1:0] Y_ARM   = 8'h11;
    localparam logic [YW-1:0] Y_DWELL = 8'h22;
    localparam logic [YW-1:0] Y_QUAL  = 8'h44;
    localparam logic [YW-1:0] Y_REL   = 8'h88;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [XW-1:0] x   = '0;
    logic [YW-1:0] y_o;
    logic [1:0]    state_o;

    always #5 clk = ~clk;

    tmr_fsm_top #(
        .XW(XW), .YW(YW), .T1(T1), .T2(T2), .X1(X1), .X2(X2),
        .Y_ARM(Y_ARM), .Y_DWELL(Y_DWELL), .Y_QUAL(Y_QUAL), .Y_REL(Y_REL)
    ) u_tmr_fsm_top (
        .clk(clk), .rst(rst), .x_i(x), .y_o(y_o), .state_o(state_o)
    );

    typedef struct {
        logic [1:0]    st;
        logic [YW-1:0] y;
        string         req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    int   m_st    = 0;
    int   m_dwell = 0;

    function automatic logic [YW-1:0] y_of(input int s);
        case (s)
            0:       return Y_ARM;
            1:       return Y_DWELL;
            2:       return Y_QUAL;
            default: return Y_REL;
        endcase
    endfunction

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Driver: sets the inputs for the next edge and queues the expected result.
    task automatic step(input logic r, input logic [XW-1:0] xv, input string req);
        exp_t e;
        int   ns;
        @(negedge clk);
        rst = r;
        x   = xv;
        if (r) begin
            ns = 0;
        end else begin
            case (m_st)
                0:       ns = (xv == X1) ? 1 : 0;
                1:       ns = (m_dwell + 1 >= T1) ? 2 : 1;
                2:       ns = ((m_dwell + 1 >= T2) && (xv == X2)) ? 3 : 2;
                default: ns = 0;
            endcase
        end
        if (r || ns != m_st) m_dwell = 0;
        else                 m_dwell = m_dwell + 1;
        m_st  = ns;
        e.st  = 2'(ns);
        e.y   = y_of(ns);
        e.req = req;
        q.push_back(e);
    endtask

    // Monitor: compares outputs just after each edge.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0 && !done) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (state_o !== e.st) begin
                fails++;
                $display("FAIL %s state: actual %0d expected %0d", e.req, state_o, e.st);
            end
            checks++;
            if (y_o !== e.y) begin
                fails++;
                $display("FAIL R7 (%s) y: actual %h expected %h", e.req, y_o, e.y);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            finish_up();
        end
    end

    initial begin
        // R8: reset state
        step(1, '0, "R8");
        step(1, X1, "R8");
        // R1: no exit on other codes, including X2
        step(0, 4'h0, "R1");
        step(0, 4'h3, "R1");
        step(0, X2,   "R1");
        // R6: long wait in arm must not pre-load the counter
        for (int i = 0; i < 10; i++) step(0, 4'h7, "R6");
        step(0, X1, "R1");
        // R2 and R6: dwell lasts T1 cycles whatever x is
        step(0, X1, "R2");
        step(0, X2, "R2");
        step(0, 4'h0, "R6");
        step(0, X2, "R2");
        // R3: early match ignored, later match taken
        step(0, X2, "R3");
        step(0, 4'h0, "R3");
        step(0, 4'h0, "R3");
        step(0, X2, "R3");
        // R4: release returns regardless of x
        step(0, X1, "R4");
        // R5: second lap, fresh count in each state
        step(0, X1, "R1");
        for (int i = 0; i < T1; i++) step(0, 4'h1, "R5");
        for (int i = 0; i < T2; i++) step(0, X2, "R5");
        step(0, X2, "R4");
        // R6: long stay in qualify, counter saturates, match still taken
        step(0, X1, "R1");
        for (int i = 0; i < T1; i++) step(0, 4'h0, "R2");
        for (int i = 0; i < 20; i++) step(0, 4'h0, "R6");
        step(0, X2, "R6");
        step(0, 4'h0, "R4");
        // R8: reset mid-dwell, then a full dwell afterwards
        step(0, X1, "R1");
        step(0, 4'h0, "R2");
        step(1, 4'h0, "R8");
        step(0, X1, "R1");
        for (int i = 0; i < T1; i++) step(0, 4'h0, "R8");
        // R8: reset mid-qualify
        step(0, 4'h0, "R3");
        step(1, X2, "R8");
        step(0, X2, "R1");
        step(0, 4'h0, "R1");
        @(posedge clk);
        #4;
        finish_up();
    end

endmodule